// File: doc/BRIEF.md
# Circular and Bit-Reverse Address Generator

This block computes effective addresses for a 32-bit load/store pipeline. Each request carries the base address register, the register paired with it (index in its low half, increment or buffer length in its high half), a raw 10-bit offset and a mode. It produces the access address, the address of the second word of a 64-bit access, and the values to write back to the base register or the paired register. The memory access itself, the decoding of other instruction fields and trap handling belong to neighbouring stages.

Five modes are supported. Three use plain base arithmetic: fixed offset, post-increment and pre-increment. Two walk a buffer through the paired register. Bit-reverse mode steps the index in reversed bit order, which suits FFT reordering. Circular mode steps the index around a ring buffer of programmable length, including the second word of a 64-bit access. The address computation is combinational. All results are registered, so they are valid on the clock edge after the request.

Top module: `agu_top`

## Requirements
- R1: The offset input is a 10-bit two's-complement value; bit 9 set means negative, and it is sign-extended to 32 bits before any addition.
- R2: Mode encoding: 0 fixed offset, 1 post-increment, 2 pre-increment, 3 bit-reverse, 4 circular; codes 5 to 7 act as mode 0. In mode 0, addr0 = base + offset, neither write-back enable is set, base_wb carries base and index_wb carries index_reg.
- R3: In post-increment mode, addr0 = base and base_wb = base + offset with base_wb_en set.
- R4: In pre-increment mode, addr0 = base + offset and base_wb carries that same value with base_wb_en set.
- R5: In modes 3 and 4, addr0 = base + zero-extended index_reg[15:0], index_wb_en is set, base_wb_en is clear, and index_wb[31:16] equals index_reg[31:16].
- R6: In bit-reverse mode, index_wb[15:0] = rev(rev(index) + rev(index_reg[31:16])), where rev mirrors all 16 bits and the sum wraps within 16 bits.
- R7: In circular mode with a non-zero length L = index_reg[31:16], when index + offset is not negative the new index is (index + offset) mod L.
- R8: In circular mode with a non-zero length, when index + offset is negative the new index is the low 16 bits of index + offset + L.
- R9: In circular mode with a length of zero, index_wb equals index_reg unchanged.
- R10: With is64 clear, addr1 = addr0. With is64 set, addr1 = addr0 + 4, except in circular mode with a non-zero length, where addr1 = base + ((index + 4) mod L).
- R11: A cycle with valid low clears both write-back enables one cycle later and holds addr0, addr1, base_wb and index_wb at their previous values.
- R12: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing mode code |
| base | input | 32 | Base address register value |
| index_reg | input | 32 | Paired register: index low half, increment or length high half |
| off10 | input | 10 | Signed offset |
| is64 | input | 1 | Request is a two-word access |
| addr0 | output | 32 | First access address |
| addr1 | output | 32 | Second word address |
| base_wb | output | 32 | New base register value |
| base_wb_en | output | 1 | Base register write-back enable |
| index_wb | output | 32 | New paired register value |
| index_wb_en | output | 1 | Paired register write-back enable |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, a 16-bit index half and a 10-bit offset. At these widths it can reach the full-range cases directly. It drives a bit-reversed sum that carries out of the top bit, circular steps with negative offsets both smaller and larger than the buffer length, a zero length, and a second-word address that wraps past the end of the ring. Reserved mode codes and idle cycles with changing inputs show that nothing is written back when it should not be.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [2:0] {
        MODE_FIXED = 3'd0,
        MODE_POST  = 3'd1,
        MODE_PRE   = 3'd2,
        MODE_BREV  = 3'd3,
        MODE_CIRC  = 3'd4
    } agu_mode_e;

    localparam int WORD_BYTES = 4;

endpackage

// File: rtl/agu_brev.sv
module agu_brev #(
    parameter int W = 16
) (
    input  logic [W-1:0] idx,
    input  logic [W-1:0] inc,
    output logic [W-1:0] idx_upd
);
    logic [W-1:0] idx_r;
    logic [W-1:0] inc_r;
    logic [W-1:0] sum_r;

    // mirror both operands, add in mirrored space, mirror back
    for (genvar i = 0; i < W; i++) begin : g_mirror
        assign idx_r[i]   = idx[W-1-i];
        assign inc_r[i]   = inc[W-1-i];
        assign idx_upd[i] = sum_r[W-1-i];
    end

    assign sum_r = idx_r + inc_r;

endmodule

// File: rtl/agu_circ.sv
module agu_circ
    import agu_pkg::*;
#(
    parameter int H     = 16,
    parameter int OFF_W = 10
) (
    input  logic [H-1:0]     idx,
    input  logic [H-1:0]     len,
    input  logic [OFF_W-1:0] off,
    output logic [H-1:0]     idx_upd,
    output logic [H-1:0]     next_word
);
    localparam int SW = H + 2;

    logic signed [SW-1:0] sum;
    logic [H-1:0]         wrapped;
    logic [H-1:0]         pos_mod;
    logic [H-1:0]         nxt_mod;

    assign sum     = $signed({2'b00, idx}) + $signed({{(SW-OFF_W){off[OFF_W-1]}}, off});
    assign wrapped = sum[H-1:0] + len;

    always_comb begin
        pos_mod = '0;
        nxt_mod = '0;
        if (len != '0) begin
            pos_mod = H'(sum[H:0] % {1'b0, len});
            nxt_mod = H'(({1'b0, idx} + (H+1)'(WORD_BYTES)) % {1'b0, len});
        end
    end

    always_comb begin
        if (len == '0)
            idx_upd = idx;
        else if (sum[SW-1])
            idx_upd = wrapped;
        else
            idx_upd = pos_mod;
    end

    assign next_word = nxt_mod;

endmodule

// File: rtl/agu_top.sv
module agu_top
    import agu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [2:0]        mode,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] index_reg,
    input  logic [OFF_W-1:0]  off10,
    input  logic              is64,
    output logic [ADDR_W-1:0] addr0,
    output logic [ADDR_W-1:0] addr1,
    output logic [ADDR_W-1:0] base_wb,
    output logic              base_wb_en,
    output logic [ADDR_W-1:0] index_wb,
    output logic              index_wb_en
);
    localparam int H = ADDR_W / 2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr0;
        logic [ADDR_W-1:0] addr1;
        logic [ADDR_W-1:0] base_wb;
        logic              base_wb_en;
        logic [ADDR_W-1:0] index_wb;
        logic              index_wb_en;
    } agu_out_t;

    agu_out_t res_d, res_q;

    logic [ADDR_W-1:0] off_sx;
    logic [ADDR_W-1:0] base_off;
    logic [ADDR_W-1:0] base_idx;
    logic [H-1:0]      idx;
    logic [H-1:0]      hi;
    logic [H-1:0]      brev_idx;
    logic [H-1:0]      circ_idx;
    logic [H-1:0]      circ_next;

    assign off_sx   = {{(ADDR_W-OFF_W){off10[OFF_W-1]}}, off10};
    assign base_off = base + off_sx;
    assign idx      = index_reg[H-1:0];
    assign hi       = index_reg[ADDR_W-1:H];
    assign base_idx = base + {{(ADDR_W-H){1'b0}}, idx};

    agu_brev #(.W(H)) u_brev (
        .idx     (idx),
        .inc     (hi),
        .idx_upd (brev_idx)
    );

    agu_circ #(.H(H), .OFF_W(OFF_W)) u_circ (
        .idx       (idx),
        .len       (hi),
        .off       (off10),
        .idx_upd   (circ_idx),
        .next_word (circ_next)
    );

    always_comb begin
        res_d             = res_q;
        res_d.base_wb_en  = 1'b0;
        res_d.index_wb_en = 1'b0;
        if (valid) begin
            res_d.addr0    = base_off;
            res_d.base_wb  = base;
            res_d.index_wb = index_reg;
            case (agu_mode_e'(mode))
                MODE_POST: begin
                    res_d.addr0      = base;
                    res_d.base_wb    = base_off;
                    res_d.base_wb_en = 1'b1;
                end
                MODE_PRE: begin
                    res_d.base_wb    = base_off;
                    res_d.base_wb_en = 1'b1;
                end
                MODE_BREV: begin
                    res_d.addr0       = base_idx;
                    res_d.index_wb    = {hi, brev_idx};
                    res_d.index_wb_en = 1'b1;
                end
                MODE_CIRC: begin
                    res_d.addr0       = base_idx;
                    res_d.index_wb    = {hi, circ_idx};
                    res_d.index_wb_en = 1'b1;
                end
                default: ;
            endcase
            if (!is64)
                res_d.addr1 = res_d.addr0;
            else if (agu_mode_e'(mode) == MODE_CIRC && hi != '0)
                res_d.addr1 = base + {{(ADDR_W-H){1'b0}}, circ_next};
            else
                res_d.addr1 = res_d.addr0 + ADDR_W'(WORD_BYTES);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            res_q <= '0;
        else
            res_q <= res_d;
    end

    assign addr0       = res_q.addr0;
    assign addr1       = res_q.addr1;
    assign base_wb     = res_q.base_wb;
    assign base_wb_en  = res_q.base_wb_en;
    assign index_wb    = res_q.index_wb;
    assign index_wb_en = res_q.index_wb_en;

endmodule

// File: rtl/agu_chk.sv
module agu_chk
    import agu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid,
    input logic [2:0]        mode,
    input logic [ADDR_W-1:0] base,
    input logic [ADDR_W-1:0] index_reg,
    input logic [OFF_W-1:0]  off10,
    input logic              is64,
    input logic [ADDR_W-1:0] addr0,
    input logic [ADDR_W-1:0] addr1,
    input logic [ADDR_W-1:0] base_wb,
    input logic              base_wb_en,
    input logic [ADDR_W-1:0] index_wb,
    input logic              index_wb_en
);
    localparam int H = ADDR_W / 2;

    a_r11_idle_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> (!base_wb_en && !index_wb_en));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> ($stable(addr0) && $stable(addr1) && $stable(base_wb) && $stable(index_wb)));

    a_r2_fixed_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && mode == 3'(MODE_FIXED)) |=>
        (!base_wb_en && !index_wb_en && base_wb == $past(base)));

    a_r3_post_old_base: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && mode == 3'(MODE_POST)) |=>
        (base_wb_en && !index_wb_en && addr0 == $past(base)));

    a_r4_pre_same: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && mode == 3'(MODE_PRE)) |=> (base_wb_en && addr0 == base_wb));

    a_r5_index_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (mode == 3'(MODE_BREV) || mode == 3'(MODE_CIRC))) |=>
        (index_wb_en && !base_wb_en &&
         index_wb[ADDR_W-1:H] == $past(index_reg[ADDR_W-1:H]) &&
         addr0 == $past(base) + {{(ADDR_W-H){1'b0}}, $past(index_reg[H-1:0])}));

    a_r7_circ_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && mode == 3'(MODE_CIRC) && index_reg[ADDR_W-1:H] != '0 && !off10[OFF_W-1]) |=>
        (index_wb[H-1:0] < index_wb[ADDR_W-1:H]));

    a_r9_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && mode == 3'(MODE_CIRC) && index_reg[ADDR_W-1:H] == '0) |=>
        (index_wb == $past(index_reg)));

    a_r10_single_word: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !is64) |=> (addr1 == addr0));

endmodule

bind agu_top agu_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_agu_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid       (valid),
    .mode        (mode),
    .base        (base),
    .index_reg   (index_reg),
    .off10       (off10),
    .is64        (is64),
    .addr0       (addr0),
    .addr1       (addr1),
    .base_wb     (base_wb),
    .base_wb_en  (base_wb_en),
    .index_wb    (index_wb),
    .index_wb_en (index_wb_en)
);

// File: tb/tb_agu_top.sv
module tb_agu_top;

    typedef struct {
        logic [31:0] addr0;
        logic [31:0] addr1;
        logic [31:0] base_wb;
        logic        base_wb_en;
        logic [31:0] index_wb;
        logic        index_wb_en;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [2:0]  mode = '0;
    logic [31:0] base = '0;
    logic [31:0] index_reg = '0;
    logic [9:0]  off10 = '0;
    logic        is64 = 1'b0;
    logic [31:0] addr0, addr1, base_wb, index_wb;
    logic        base_wb_en, index_wb_en;

    int checks = 0;
    int fails = 0;
    exp_t q[$];
    exp_t model;

    always #5 clk = ~clk;

    agu_top dut (
        .clk (clk), .rst_n (rst_n), .valid (valid), .mode (mode),
        .base (base), .index_reg (index_reg), .off10 (off10), .is64 (is64),
        .addr0 (addr0), .addr1 (addr1), .base_wb (base_wb), .base_wb_en (base_wb_en),
        .index_wb (index_wb), .index_wb_en (index_wb_en)
    );

    function automatic logic [15:0] rev16(input logic [15:0] v);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = v[15-i];
        return r;
    endfunction

    function automatic logic [31:0] sx(input logic [9:0] o);
        return {{22{o[9]}}, o};
    endfunction

    // drive one cycle and push the expected result of that cycle
    task automatic step(input logic v, input logic [2:0] m, input logic [31:0] b,
                        input logic [31:0] ir, input logic [9:0] o, input logic w64,
                        input string tag);
        logic [15:0] idx, hi, ni;
        int s;
        @(negedge clk);
        valid = v; mode = m; base = b; index_reg = ir; off10 = o; is64 = w64;
        idx = ir[15:0];
        hi  = ir[31:16];
        model.base_wb_en  = 1'b0;
        model.index_wb_en = 1'b0;
        if (v) begin
            model.addr0    = b + sx(o);
            model.base_wb  = b;
            model.index_wb = ir;
            if (m == 3'd1) begin
                model.addr0 = b; model.base_wb = b + sx(o); model.base_wb_en = 1'b1;
            end else if (m == 3'd2) begin
                model.base_wb = b + sx(o); model.base_wb_en = 1'b1;
            end else if (m == 3'd3) begin
                model.addr0 = b + {16'h0, idx};
                ni = rev16(rev16(idx) + rev16(hi));
                model.index_wb = {hi, ni}; model.index_wb_en = 1'b1;
            end else if (m == 3'd4) begin
                model.addr0 = b + {16'h0, idx};
                s = int'(idx) + int'($signed(o));
                if (hi == 0) ni = idx;
                else if (s < 0) ni = 16'(s + int'(hi));
                else ni = 16'(s % int'(hi));
                model.index_wb = {hi, ni}; model.index_wb_en = 1'b1;
            end
            if (!w64) model.addr1 = model.addr0;
            else if (m == 3'd4 && hi != 0)
                model.addr1 = b + 32'((int'(idx) + 4) % int'(hi));
            else model.addr1 = model.addr0 + 32'd4;
        end
        model.tag = tag;
        q.push_back(model);
    endtask

    // monitor: compares one result per cycle, away from the edge
    always @(posedge clk) begin
        if (rst_n && q.size() > 0) begin
            exp_t e;
            #1;
            e = q.pop_front();
            checks++;
            if (addr0 !== e.addr0 || addr1 !== e.addr1 || base_wb !== e.base_wb ||
                base_wb_en !== e.base_wb_en || index_wb !== e.index_wb ||
                index_wb_en !== e.index_wb_en) begin
                fails++;
                $display("FAIL %s: got a0=%h a1=%h bwb=%h/%b iwb=%h/%b exp a0=%h a1=%h bwb=%h/%b iwb=%h/%b",
                         e.tag, addr0, addr1, base_wb, base_wb_en, index_wb, index_wb_en,
                         e.addr0, e.addr1, e.base_wb, e.base_wb_en, e.index_wb, e.index_wb_en);
            end
        end
    end

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: got hang expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        model = '{addr0: '0, addr1: '0, base_wb: '0, base_wb_en: 1'b0,
                  index_wb: '0, index_wb_en: 1'b0, tag: ""};
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if ({addr0, addr1, base_wb, base_wb_en, index_wb, index_wb_en} !== '0) begin
            fails++;
            $display("FAIL R12 reset: got a0=%h a1=%h bwb=%h iwb=%h expected all zero",
                     addr0, addr1, base_wb, index_wb);
        end
        @(negedge clk);
        rst_n = 1'b1;

        step(1, 3'd0, 32'h0000_1000, 32'h0000_0000, 10'd100, 0, "R2 fixed positive");
        step(1, 3'd0, 32'h0000_1000, 32'h1234_5678, 10'h3F0, 0, "R1 fixed negative offset");
        step(1, 3'd6, 32'h2000_0000, 32'hAAAA_5555, 10'h200, 1, "R2 reserved mode");
        step(1, 3'd1, 32'h0000_4000, 32'h0, 10'd8, 0, "R3 post increment");
        step(1, 3'd1, 32'h0000_4008, 32'h0, 10'd8, 1, "R3 post is64 R10");
        step(1, 3'd2, 32'h0000_4000, 32'h0, 10'h3FC, 0, "R4 pre decrement R1");
        step(0, 3'd1, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 10'd5, 1, "R11 idle hold");
        step(0, 3'd3, 32'h1111_1111, 32'h0001_0001, 10'd1, 0, "R11 idle again");
        step(1, 3'd3, 32'h8000_0000, 32'h0100_0000, 10'd0, 0, "R6 brev first");
        step(1, 3'd3, 32'h8000_0000, 32'h0100_0100, 10'd0, 0, "R6 brev second");
        step(1, 3'd3, 32'h8000_0000, 32'hFFFF_8000, 10'd0, 1, "R6 brev carry out R5");
        step(1, 3'd3, 32'h0000_0100, 32'h4000_0180, 10'd3, 0, "R6 brev mid R5");
        step(1, 3'd4, 32'h0000_2000, 32'h0008_0006, 10'd4, 1, "R7 circ wrap R10");
        step(1, 3'd4, 32'h0000_2000, 32'h0008_0002, 10'd3, 0, "R7 circ no wrap");
        step(1, 3'd4, 32'h0000_2000, 32'h0008_0002, 10'h3FB, 1, "R8 circ negative");
        step(1, 3'd4, 32'h0000_2000, 32'h0008_0000, 10'h3EC, 0, "R8 circ deep negative");
        step(1, 3'd4, 32'h0000_2000, 32'h0000_0010, 10'd4, 1, "R9 circ zero length R10");
        step(1, 3'd4, 32'h0000_3000, 32'h000C_0004, 10'd8, 1, "R10 circ second word");
        step(0, 3'd4, 32'h0, 32'h0, 10'd0, 0, "R11 idle after circ");
        step(1, 3'd2, 32'hFFFF_FFF0, 32'h0, 10'd32, 1, "R4 pre wrap R10");
        step(1, 3'd7, 32'h0000_0040, 32'h0003_0001, 10'h3FF, 0, "R2 reserved seven");
        step(0, 3'd0, 32'h0, 32'h0, 10'd0, 0, "R11 final idle");
        repeat (4) @(negedge clk);
        valid = 1'b0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule